// File: doc/BRIEF.md
# Divider-Chain Timer with Periodic Tick Taps

This block is a free-running binary divider chain, clocked by the operating clock, that produces three things at once. The first is an 8-bit count value that software can read. The second is a fixed-period overflow event. The third is a periodic real-time event. The real-time period is picked from four taps high in the same chain. A small fixed prescaler sits ahead of the readable stages, so the readable count advances once every four clocks. The overflow event fires when the readable stages wrap, which is once every 1024 clocks.

Each of the two events sets a sticky flag. Each flag has its own enable, and an interrupt request stays high while both the flag and its enable are set. Software clears a flag by writing 1 to that flag's acknowledge bit. The selected real-time tap is also exported as a one-cycle tick, which drives a watchdog's counting. Changing the rate select therefore also changes how fast the watchdog counts. The chain is a synchronous counter, and each tap event is decoded as the carry that flows out of the tap bit.

Top module: `tap_timer`

## Requirements
- R1: After reset the count register (bus_addr 0) reads 0 and the control register (bus_addr 1) reads 8'h03. Both flags are clear, both enables are clear, the rate select is 2'b11, and ovf_irq, rti_irq and rti_tick are low.
- R2: After N clocks since reset release, the count register reads (N/4) mod 256. Writes to the count register have no effect on it.
- R3: The overflow flag (control bit 7) becomes 1 on clock 1024 after reset release, and again on every later multiple of 1024.
- R4: The rate select lives in control bits 1:0 and reads back as written. The real-time flag (control bit 6) becomes 1 each time the clock count since release reaches a multiple of 2^(RTI_LSB+1+code). With the default RTI_LSB=13 that period is 2^14 clocks for code 00 and 2^17 clocks for code 11.
- R5: rti_tick is high for exactly one cycle, in the same cycle that the real-time flag is set. It pulses whatever the enable bits hold.
- R6: Flags stay set until they are acknowledged, and writes to bits 7 and 6 do not change them. The overflow enable is bit 5 and the real-time enable is bit 4. ovf_irq and rti_irq are each high exactly while their flag and enable are both 1.
- R7: Writing 1 to bit 3 clears the overflow flag, and writing 1 to bit 2 clears the real-time flag. Writing 0 to these bits leaves the flags alone, and both bits always read 0.
- R8: If an acknowledge lands in the same cycle as a new event for that flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock driving the divider chain |
| rst_n | input | 1 | Asynchronous active-low reset; clears the whole chain |
| bus_addr | input | 1 | Register select: 0 count, 1 control |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the selected register |
| ovf_irq | output | 1 | Overflow interrupt request |
| rti_irq | output | 1 | Real-time interrupt request |
| rti_tick | output | 1 | One-cycle pulse of the selected real-time tap, for the watchdog |

## Verification
The assertions take bus_wr to be a single-cycle strobe, sampled only at clock edges, and assume the tap periods are longer than two clocks. Because of that, back-to-back ticks and a set in the same cycle as a clear are never treated as illegal. The stimulus only changes the rate while the chain is well away from a carry through any candidate tap. This avoids the dropped or extra tick that a rate switch next to a boundary can cause. One acknowledge is deliberately placed on the very edge of an overflow event to exercise the rule that a set beats a clear. The bench overrides RTI_LSB to 10 so that all four rates fit in a short run, and it works out every expected period from that value.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
   localparam int DATA_W       = 8;
   localparam int SEL_BITS     = 2;
   localparam int NUM_EVENTS   = 2;
   localparam int EV_OVF       = 0;
   localparam int EV_RTI       = 1;

   localparam int B_OVF_FLAG   = 7;
   localparam int B_RTI_FLAG   = 6;
   localparam int B_OVF_EN     = 5;
   localparam int B_RTI_EN     = 4;
   localparam int B_OVF_ACK    = 3;
   localparam int B_RTI_ACK    = 2;

   typedef enum logic {
      SEL_COUNT = 1'b0,
      SEL_CTRL  = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic                ovf_en;
      logic                rti_en;
      logic [SEL_BITS-1:0] rate;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{ovf_en: 1'b0, rti_en: 1'b0, rate: '1};
endpackage

// File: rtl/tmr_chain.sv
module tmr_chain #(
   parameter int PRE_BITS   = 2,
   parameter int VIS_BITS   = 8,
   parameter int CHAIN_BITS = 15,
   localparam int TOTAL     = PRE_BITS + CHAIN_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [VIS_BITS-1:0] count,
   output logic [TOTAL-1:0]    carry
);
   logic [TOTAL-1:0] stage_q;

   generate
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("tmr_chain: PRE_BITS must be at least 1");
      end
      if (VIS_BITS > CHAIN_BITS) begin : g_bad_vis
         $error("tmr_chain: readable stages exceed the chain length");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= stage_q + 1'b1;
   end

   // carry[i] is high when bit i is about to fall (all bits up to i are 1)
   generate
      for (genvar i = 0; i < TOTAL; i++) begin : g_carry
         if (i == 0) begin : g_lsb
            assign carry[i] = stage_q[0];
         end else begin : g_up
            assign carry[i] = carry[i-1] & stage_q[i];
         end
      end
   endgenerate

   assign count = stage_q[PRE_BITS +: VIS_BITS];

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      carry[PRE_BITS-1] |=> count == $past(count) + 1'b1) else $error("count step"); // R2
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !carry[PRE_BITS-1] |=> $stable(count)) else $error("count hold"); // R2
endmodule

// File: rtl/tmr_rate_sel.sv
module tmr_rate_sel #(
   parameter int TOTAL    = 17,
   parameter int TAP_LSB  = 13,
   parameter int SEL_BITS = 2,
   localparam int NUM_TAPS = 1 << SEL_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TOTAL-1:0]    carry,
   input  logic [SEL_BITS-1:0] sel,
   output logic                evt,
   output logic                tick
);
   logic [NUM_TAPS-1:0] taps;

   generate
      if (TAP_LSB < 1) begin : g_bad_lsb
         $error("tmr_rate_sel: lowest tap must divide by at least 4");
      end
      if (TAP_LSB + NUM_TAPS > TOTAL) begin : g_bad_top
         $error("tmr_rate_sel: taps run past the end of the chain");
      end
      for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
         assign taps[k] = carry[TAP_LSB + k];
      end
   endgenerate

   assign evt = taps[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick <= 1'b0;
      else        tick <= evt;
   end

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick) else $error("tick wider than one cycle"); // R5
   AST_TICK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick) |-> $past(evt)) else $error("tick without tap carry"); // R5
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign irq = flag & en;

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag) else $error("flag dropped without ack"); // R6
   AST_FLAG_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(set)) else $error("flag rose without event"); // R6
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set |=> !flag) else $error("ack did not clear"); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag) else $error("event lost"); // R8
endmodule

// File: rtl/tap_timer.sv
module tap_timer
   import tap_timer_pkg::*;
#(
   parameter int PRE_BITS   = 2,
   parameter int VIS_BITS   = 8,
   parameter int CHAIN_BITS = 15,
   parameter int RTI_LSB    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ovf_irq,
   output logic              rti_irq,
   output logic              rti_tick
);
   localparam int TOTAL   = PRE_BITS + CHAIN_BITS;
   localparam int OVF_TAP = PRE_BITS + VIS_BITS - 1;

   generate
      if (VIS_BITS > DATA_W) begin : g_bad_width
         $error("tap_timer: readable count wider than the data bus");
      end
   endgenerate

   logic [VIS_BITS-1:0]   count;
   logic [TOTAL-1:0]      carry;
   logic                  rti_evt;
   ctl_t                  ctl_q;
   logic                  ctl_wr;
   logic [NUM_EVENTS-1:0] ev_set, ev_clr, ev_en, ev_flag, ev_irq;
   logic [DATA_W-1:0]     count_ext, ctl_rd;

   tmr_chain #(
      .PRE_BITS  (PRE_BITS),
      .VIS_BITS  (VIS_BITS),
      .CHAIN_BITS(CHAIN_BITS)
   ) u_chain (
      .clk  (clk),
      .rst_n(rst_n),
      .count(count),
      .carry(carry)
   );

   tmr_rate_sel #(
      .TOTAL   (TOTAL),
      .TAP_LSB (RTI_LSB),
      .SEL_BITS(SEL_BITS)
   ) u_rate (
      .clk  (clk),
      .rst_n(rst_n),
      .carry(carry),
      .sel  (ctl_q.rate),
      .evt  (rti_evt),
      .tick (rti_tick)
   );

   // control register
   assign ctl_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
      end else if (ctl_wr) begin
         ctl_q.ovf_en <= bus_wdata[B_OVF_EN];
         ctl_q.rti_en <= bus_wdata[B_RTI_EN];
         ctl_q.rate   <= bus_wdata[SEL_BITS-1:0];
      end
   end

   // event flags
   assign ev_set[EV_OVF] = carry[OVF_TAP];
   assign ev_set[EV_RTI] = rti_evt;
   assign ev_clr[EV_OVF] = ctl_wr && bus_wdata[B_OVF_ACK];
   assign ev_clr[EV_RTI] = ctl_wr && bus_wdata[B_RTI_ACK];
   assign ev_en[EV_OVF]  = ctl_q.ovf_en;
   assign ev_en[EV_RTI]  = ctl_q.rti_en;

   generate
      for (genvar f = 0; f < NUM_EVENTS; f++) begin : g_flag
         tmr_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (ev_set[f]),
            .clr  (ev_clr[f]),
            .en   (ev_en[f]),
            .flag (ev_flag[f]),
            .irq  (ev_irq[f])
         );
      end
   endgenerate

   assign ovf_irq = ev_irq[EV_OVF];
   assign rti_irq = ev_irq[EV_RTI];

   // read path
   always_comb begin
      count_ext = '0;
      count_ext[VIS_BITS-1:0] = count;
      ctl_rd = '0;
      ctl_rd[B_OVF_FLAG] = ev_flag[EV_OVF];
      ctl_rd[B_RTI_FLAG] = ev_flag[EV_RTI];
      ctl_rd[B_OVF_EN]   = ctl_q.ovf_en;
      ctl_rd[B_RTI_EN]   = ctl_q.rti_en;
      ctl_rd[SEL_BITS-1:0] = ctl_q.rate;
   end

   assign bus_rdata = (reg_sel_e'(bus_addr) == SEL_CTRL) ? ctl_rd : count_ext;

   AST_OVF_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ctl_q.ovf_en) else $error("ovf irq without enable"); // R6
   AST_RTI_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rti_irq |-> ctl_q.rti_en) else $error("rti irq without enable"); // R6
   AST_TICK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      rti_tick |-> ev_flag[EV_RTI]) else $error("tick without flag"); // R5
endmodule

// File: tb/tb_tap_timer.sv
`timescale 1ns/1ps
module tb_tap_timer;
   localparam int RTI_LSB = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ovf_irq, rti_irq, rti_tick;

   int cyc;
   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;

   tap_timer #(.RTI_LSB(RTI_LSB)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ovf_irq(ovf_irq), .rti_irq(rti_irq), .rti_tick(rti_tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(1'b0, d); chk(d == 8'h00, "R1 count", d, 0);
      rd(1'b1, d); chk(d == 8'h03, "R1 control", d, 8'h03);
      chk({ovf_irq, rti_irq, rti_tick} == 3'b000, "R1 outputs", {ovf_irq, rti_irq, rti_tick}, 0);
   endtask

   task automatic t_count();
      logic [7:0] d;
      int pts[6] = '{1, 3, 4, 7, 100, 517};
      foreach (pts[i]) begin
         wait_cyc(pts[i]);
         rd(1'b0, d);
         chk(d == ((pts[i] >> 2) & 255), "R2 count value", d, (pts[i] >> 2) & 255);
      end
      wait_cyc(600);
      wr(1'b0, 8'hAA);
      rd(1'b0, d);
      chk(d == ((cyc >> 2) & 255), "R2 write ignored", d, (cyc >> 2) & 255);
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      wait_cyc(1020);
      rd(1'b0, d); chk(d == 8'd255, "R2 count before wrap", d, 255);
      wait_cyc(1023);
      rd(1'b1, d); chk(d[7] == 1'b0, "R3 ovf flag before 1024", d[7], 0);
      wait_cyc(1024);
      rd(1'b1, d); chk(d[7] == 1'b1, "R3 ovf flag at 1024", d[7], 1);
      rd(1'b0, d); chk(d == 8'd0, "R2 count wrapped", d, 0);
      chk(ovf_irq == 1'b0, "R6 ovf irq masked", ovf_irq, 0);
      wait_cyc(1030);
      wr(1'b1, 8'h23);
      chk(ovf_irq == 1'b1, "R6 ovf irq enabled", ovf_irq, 1);
      wait_cyc(1100);
      wr(1'b1, 8'h2B);
      rd(1'b1, d); chk(d == 8'h23, "R7 ack clears and reads 0", d, 8'h23);
      chk(ovf_irq == 1'b0, "R7 irq drops after ack", ovf_irq, 0);
      wait_cyc(1200);
      wr(1'b1, 8'hE3);
      rd(1'b1, d); chk(d[7:6] == 2'b00, "R6 flags not writable", d[7:6], 0);
   endtask

   task automatic t_set_wins();
      logic [7:0] d;
      wait_cyc(2047);
      wr(1'b1, 8'h2B);
      rd(1'b1, d); chk(d[7] == 1'b1, "R8 event beats ack", d[7], 1);
      wait_cyc(2100);
      wr(1'b1, 8'h23);
      rd(1'b1, d); chk(d[7] == 1'b1, "R7 zero ack keeps flag", d[7], 1);
      chk(ovf_irq == 1'b1, "R6 irq while flag and enable", ovf_irq, 1);
      wait_cyc(2200);
      wr(1'b1, 8'h2B);
      rd(1'b1, d); chk(d[7] == 1'b0, "R7 ack clears", d[7], 0);
   endtask

   task automatic t_rti_default();
      logic [7:0] d;
      int per = 1 << (RTI_LSB + 1 + 3);
      wait_cyc(per - 1);
      rd(1'b1, d); chk(d[6] == 1'b0, "R4 rti flag before period", d[6], 0);
      chk(rti_tick == 1'b0, "R5 no tick before period", rti_tick, 0);
      wait_cyc(per);
      rd(1'b1, d); chk(d[6] == 1'b1, "R4 rti flag at period", d[6], 1);
      chk(rti_tick == 1'b1, "R5 tick with flag", rti_tick, 1);
      chk(rti_irq == 1'b0, "R6 rti irq masked", rti_irq, 0);
      wait_cyc(per + 1);
      chk(rti_tick == 1'b0, "R5 tick one cycle", rti_tick, 0);
      rd(1'b1, d); chk(d[6] == 1'b1, "R6 rti flag sticky", d[6], 1);
   endtask

   task automatic t_rates();
      logic [7:0] d;
      int wat[3] = '{16500, 18500, 20600};
      for (int code = 0; code < 3; code++) begin
         int per = 1 << (RTI_LSB + 1 + code);
         int nxt = ((wat[code] / per) + 1) * per;
         wait_cyc(wat[code]);
         wr(1'b1, 8'h34 | code[7:0]);
         rd(1'b1, d);
         chk(d[5:0] == (6'h30 | code[5:0]), "R4 rate readback", d[5:0], 6'h30 | code[5:0]);
         chk(d[6] == 1'b0, "R7 rti ack clears", d[6], 0);
         wait_cyc(nxt - 1);
         rd(1'b1, d); chk(d[6] == 1'b0, "R4 no early rti", d[6], 0);
         chk(rti_tick == 1'b0, "R5 no early tick", rti_tick, 0);
         wait_cyc(nxt);
         rd(1'b1, d); chk(d[6] == 1'b1, "R4 rti at selected period", d[6], 1);
         chk(rti_tick == 1'b1, "R5 tick at selected period", rti_tick, 1);
         chk(rti_irq == 1'b1, "R6 rti irq enabled", rti_irq, 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_overflow();
      t_set_wins();
      t_rti_default();
      t_rates();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 24576);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule